// File: doc/BRIEF.md
# Dual-Chain Even/Odd Carry Adder

This block is a two's-complement/unsigned binary adder built from 8-bit slices. Inside a slice, the carries are not rippled from bit to bit. Two separate recursive chains, each four stages deep, produce pseudo-carries. One chain serves the even bit positions and the other the odd ones. Neither chain reads anything the other chain computes.

Each chain step merges two adjacent generate terms (g_i OR g_{i-1}). It uses a span-two propagate made of the XOR-propagates of both bits and the OR-propagate two positions down. A real carry is recovered by gating the pseudo-carry of a position with that position's OR-propagate (a OR b). Each sum bit is the XOR-propagate of its position combined with the real carry entering it.

A wrapper chains N such slices into a wider adder of 8·N bits. The carry-out of one slice is the carry-in of the next, and the last carry-out is brought to a port. The model is purely combinational, with no clock or storage. It is meant for datapaths that want a short, regular carry structure per byte.

Top module: `dcadd_wide`

## Requirements
- R1: For every 8-bit slice and every combination of its operands and carry-in, the slice result {cout, S} equals A + B + cin as a 9-bit unsigned value.
- R2: The carry entering each bit position i (observable as S[i] XOR A[i] XOR B[i]) equals the ripple carry of the operands below i. At position 0 this is cin; above it, c_i = a_i·b_i + (a_i XOR b_i)·c_{i-1}.
- R3: A carry-in of 1 with every bit propagating (A = 0xFF, B = 0x00) gives S = 0x00 and cout = 1. With A = 0x55, B = 0xAA and cin = 0 it gives S = 0xFF and cout = 0.
- R4: For N slices, {cout_o, sum_o} equals a_i + b_i + cin_i as an (8·N+1)-bit unsigned value.
- R5: A carry generated in a lower slice reaches every higher slice. All-ones plus zero with cin_i = 1 gives sum_o = 0 and cout_o = 1, and 0x…00FF + 1 gives 0x…0100.
- R6: All-zero operands with cin_i = 0 give sum_o = 0 and cout_o = 0.
- R7: All-ones plus all-ones with carry-in 1 gives an all-ones sum and a carry-out of 1, both in one slice and across the full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8·N | First operand |
| b_i | input | 8·N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 8·N | Sum, modulo 2^(8·N) |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The in-design assertions assume that the operands and carry-in are fully known values. Each check is skipped while any input bit is unknown, so the assertions never judge the block on undriven inputs. The bench drives every input from time zero with defined values and changes them only on the rising clock edge. All comparisons happen on the falling edge, after the combinational paths have settled. A single-slice instance walks the full 17-bit input space, and a 64-bit instance takes directed boundary patterns followed by random operands.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;
   // Width of one slice; the two chains each cover half of its positions.
   localparam int unsigned SLICE_W = 8;
   localparam int unsigned HALF_W  = SLICE_W / 2;

   typedef logic [SLICE_W-1:0] slice_t;
   typedef logic [HALF_W-1:0]  half_t;

   // Per-bit terms: generate, OR-propagate, XOR-propagate.
   typedef struct packed {
      slice_t gen;
      slice_t orp;
      slice_t xrp;
   } bitterm_t;
endpackage

// File: rtl/dcadd_bitterms.sv
module dcadd_bitterms
   import dcadd_pkg::*;
(
   input  slice_t   a_i,
   input  slice_t   b_i,
   output bitterm_t bt_o
);
   always_comb begin
      bt_o.gen = a_i & b_i;
      bt_o.orp = a_i | b_i;
      bt_o.xrp = a_i ^ b_i;
   end
endmodule

// File: rtl/dcadd_even_chain.sv
module dcadd_even_chain
   import dcadd_pkg::*;
(
   input  bitterm_t bt_i,
   input  logic     cin_i,
   output half_t    h_o      // h_o[k] is the pseudo-carry of position 2k
);
   initial begin
      if (SLICE_W % 2 != 0) $error("slice width must be even");
   end

   for (genvar k = 0; k < int'(HALF_W); k++) begin : g_link
      if (k == 0) begin : g_head
         assign h_o[k] = bt_i.gen[0] | cin_i;
      end else begin : g_body
         logic merged_g;
         logic span_p;
         assign merged_g = bt_i.gen[2*k] | bt_i.gen[2*k-1];
         assign span_p   = bt_i.xrp[2*k] & bt_i.xrp[2*k-1] & bt_i.orp[2*k-2];
         assign h_o[k]   = merged_g | (span_p & h_o[k-1]);
      end
   end
endmodule

// File: rtl/dcadd_odd_chain.sv
module dcadd_odd_chain
   import dcadd_pkg::*;
(
   input  bitterm_t bt_i,
   input  logic     cin_i,
   output half_t    h_o      // h_o[k] is the pseudo-carry of position 2k+1
);
   for (genvar k = 0; k < int'(HALF_W); k++) begin : g_link
      logic merged_g;
      logic span_p;
      assign merged_g = bt_i.gen[2*k+1] | bt_i.gen[2*k];
      if (k == 0) begin : g_head
         // The OR-propagate below bit 0 is taken as 1; the carry-in acts as g[-1].
         assign span_p = bt_i.xrp[1] & bt_i.xrp[0];
         assign h_o[k] = merged_g | (span_p & cin_i);
      end else begin : g_body
         assign span_p = bt_i.xrp[2*k+1] & bt_i.xrp[2*k] & bt_i.orp[2*k-1];
         assign h_o[k] = merged_g | (span_p & h_o[k-1]);
      end
   end
endmodule

// File: rtl/dcadd_slice.sv
module dcadd_slice
   import dcadd_pkg::*;
(
   input  slice_t a_i,
   input  slice_t b_i,
   input  logic   cin_i,
   output slice_t sum_o,
   output logic   cout_o
);
   bitterm_t bt;
   half_t    h_even;
   half_t    h_odd;
   slice_t   pseudo;
   slice_t   carry;

   dcadd_bitterms u_terms (
      .a_i (a_i),
      .b_i (b_i),
      .bt_o(bt)
   );

   dcadd_even_chain u_even (
      .bt_i (bt),
      .cin_i(cin_i),
      .h_o  (h_even)
   );

   dcadd_odd_chain u_odd (
      .bt_i (bt),
      .cin_i(cin_i),
      .h_o  (h_odd)
   );

   for (genvar k = 0; k < int'(HALF_W); k++) begin : g_merge
      assign pseudo[2*k]   = h_even[k];
      assign pseudo[2*k+1] = h_odd[k];
   end

   assign carry = bt.orp & pseudo;

   for (genvar i = 0; i < int'(SLICE_W); i++) begin : g_sum
      if (i == 0) begin : g_lsb
         assign sum_o[i] = bt.xrp[i] ^ cin_i;
      end else begin : g_up
         assign sum_o[i] = bt.xrp[i] ^ carry[i-1];
      end
   end

   assign cout_o = carry[SLICE_W-1];

   always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
         // R1
         slice_sum_chk: assert ({cout_o, sum_o} ==
                                ({1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i}))
            else $error("slice result differs from operand sum");
         for (int i = 0; i < int'(SLICE_W); i++) begin
            // R2
            carry_rec_chk: assert (carry[i] ==
                                   (bt.gen[i] | (bt.xrp[i] & ((i == 0) ? cin_i : carry[(i == 0) ? 0 : i-1]))))
               else $error("carry at bit %0d breaks ripple recurrence", i);
            // R2
            gen_force_chk: assert (!bt.gen[i] || carry[i])
               else $error("generating bit %0d produced no carry", i);
         end
      end
   end
endmodule

// File: rtl/dcadd_wide.sv
module dcadd_wide
   import dcadd_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic [N*SLICE_W-1:0] a_i,
   input  logic [N*SLICE_W-1:0] b_i,
   input  logic                 cin_i,
   output logic [N*SLICE_W-1:0] sum_o,
   output logic                 cout_o
);
   localparam int unsigned W = N * SLICE_W;

   if (N < 1) begin : g_bad_n
      initial $error("slice count must be at least one");
   end

   logic [N:0] link;
   assign link[0] = cin_i;

   for (genvar s = 0; s < int'(N); s++) begin : g_slice
      dcadd_slice u_slice (
         .a_i   (a_i[s*SLICE_W +: SLICE_W]),
         .b_i   (b_i[s*SLICE_W +: SLICE_W]),
         .cin_i (link[s]),
         .sum_o (sum_o[s*SLICE_W +: SLICE_W]),
         .cout_o(link[s+1])
      );
   end

   assign cout_o = link[N];

   always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
         // R4
         wide_sum_chk: assert ({cout_o, sum_o} ==
                               ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
            else $error("wide result differs from operand sum");
      end
   end
endmodule

// File: tb/sim_dcadd_wide.sv
`timescale 1ns/1ps
module sim_dcadd_wide;
   localparam int NW = 8;
   localparam int WW = NW * 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [WW-1:0] wa = '0, wb = '0, wsum;
   logic          wcin = 1'b0, wcout;
   logic [7:0]    na = '0, nb = '0, nsum;
   logic          ncin = 1'b0, ncout;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   dcadd_wide #(.N(NW)) u0 (
      .a_i(wa), .b_i(wb), .cin_i(wcin), .sum_o(wsum), .cout_o(wcout)
   );

   dcadd_wide #(.N(1)) u1 (
      .a_i(na), .b_i(nb), .cin_i(ncin), .sum_o(nsum), .cout_o(ncout)
   );

   task automatic chk_narrow(input string tag);
      logic [8:0] exp_v;
      logic [7:0] exp_in, got_in;
      logic       c;
      exp_v = {1'b0, na} + {1'b0, nb} + {8'd0, ncin};
      checks++;
      if ({ncout, nsum} !== exp_v) begin
         errors++;
         $display("FAIL %s: %h+%h+%b got %h expected %h", tag, na, nb, ncin, {ncout, nsum}, exp_v);
      end
      c = ncin;
      for (int i = 0; i < 8; i++) begin
         exp_in[i] = c;
         c = (na[i] & nb[i]) | (c & (na[i] ^ nb[i]));
      end
      got_in = nsum ^ na ^ nb;
      checks++;
      if (got_in !== exp_in) begin
         errors++;
         $display("FAIL R2: carries into bits got %b expected %b", got_in, exp_in);
      end
   endtask

   task automatic chk_wide(input string tag);
      logic [WW:0] exp_v;
      exp_v = {1'b0, wa} + {1'b0, wb} + {{WW{1'b0}}, wcin};
      checks++;
      if ({wcout, wsum} !== exp_v) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, {wcout, wsum}, exp_v);
      end
   endtask

   task automatic step_n(input logic [7:0] a, input logic [7:0] b, input logic c, input string tag);
      @(posedge clk);
      na = a; nb = b; ncin = c;
      @(negedge clk);
      chk_narrow(tag);
   endtask

   task automatic step_w(input logic [WW-1:0] a, input logic [WW-1:0] b, input logic c, input string tag);
      @(posedge clk);
      wa = a; wb = b; wcin = c;
      @(negedge clk);
      chk_wide(tag);
   endtask

   initial begin
      @(negedge clk);
      chk_narrow("R6");   // all-zero inputs from time zero
      chk_wide("R6");

      step_n(8'hFF, 8'h00, 1'b1, "R3");
      step_n(8'h55, 8'hAA, 1'b0, "R3");
      step_n(8'hFF, 8'hFF, 1'b1, "R7");
      step_n(8'h80, 8'h80, 1'b0, "R1");
      step_n(8'h00, 8'h00, 1'b0, "R6");

      step_w('1, '0, 1'b1, "R5");
      step_w({{(WW-8){1'b0}}, 8'hFF}, {{(WW-1){1'b0}}, 1'b1}, 1'b0, "R5");
      step_w('1, '1, 1'b1, "R7");
      step_w({(WW/8){8'hA5}}, {(WW/8){8'h5A}}, 1'b1, "R5");
      step_w('0, '0, 1'b0, "R6");

      // R1 exhaustive single slice, R4 random wide operands in the same cycles
      for (int v = 0; v < 131072; v++) begin
         @(posedge clk);
         na   = v[7:0];
         nb   = v[15:8];
         ncin = v[16];
         wa   = WW'({$urandom, $urandom});
         wb   = WW'({$urandom, $urandom});
         wcin = 1'($urandom);
         @(negedge clk);
         chk_narrow("R1");
         chk_wide("R4");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule